// File: doc/BRIEF.md
# I2C Write-Only Slave Receiver

This block is an I2C target that only receives. It synchronizes the SCL and SDA lines into the system clock domain and finds start and stop conditions. It collects the address byte and compares it with a 7-bit own address. After a match it shifts in data bytes and drives the acknowledge bit by itself. Each accepted byte, including the matching address byte, goes into a single-entry receive buffer that a host drains with a read strobe.

The buffer can hold only one byte. A byte that completes while the buffer still holds unread data is lost: the block does not acknowledge it and sets a sticky overflow flag. A byte that completes while the overflow flag is set is also refused. This holds even after the buffer has been read, so the host must clear the overflow explicitly before traffic is accepted again. An interrupt flag records every byte that completes after an address match. That flag drives a level interrupt output until the host clears it.

Top module: `i2c_rx_slave`

## Requirements
- R1: A start condition is SDA falling while SCL is high. From any state it begins reception of an address byte. A stop condition is SDA rising while SCL is high. It returns the block to idle and releases SDA. Bits that arrive after a stop and before the next start have no effect.
- R2: Bits are sampled on SCL rising edges, MSB first. The first byte after a start holds address bits 7..1 and a direction bit in bit 0. A match needs bits 7..1 equal to `own_addr_i` and bit 0 equal to 0 (write).
- R3: When a matching address byte completes with both flags clear, `sda_oe_o` goes to 1 on the SCL falling edge after the eighth bit. It returns to 0 on the falling edge after the ninth bit. The buffer then holds the full address byte and `buf_full_o` is 1.
- R4: Each data byte that completes after a match, with both flags clear, is acknowledged in the same way. It is copied into `rxbuf_o` and sets `buf_full_o`.
- R5: An address byte that does not match is not acknowledged and changes no flag and no buffer contents. The block ignores the bus until the next start.
- R6: When a byte completes while `buf_full_o` is 1, with no read strobe in that cycle, it is not acknowledged, `rxbuf_o` keeps its value and `ovf_o` becomes 1.
- R7: When a byte completes while `ovf_o` is 1, it is not acknowledged and `rxbuf_o` keeps its value. This holds even when `buf_full_o` is 0.
- R8: A one-cycle `rd_strobe_i` clears `buf_full_o`. It does not change `ovf_o`.
- R9: `ovf_o` is cleared only by `ovf_clr_i`. If an overflow occurs in the same cycle as the clear, the flag stays set.
- R10: `irq_o` becomes 1 on every byte that completes after a match, whether or not the byte is accepted. It stays 1 until `irq_clr_i`. If a new byte completes in the same cycle as the clear, the flag stays set.
- R11: When `rd_strobe_i` falls in the same cycle as a byte completion, the read is applied first. The byte is acknowledged and stored, and `buf_full_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (acknowledge) |
| own_addr_i | input | 7 | Own 7-bit address |
| rd_strobe_i | input | 1 | Host read of the receive buffer |
| ovf_clr_i | input | 1 | Host clear of the overflow flag |
| irq_clr_i | input | 1 | Host clear of the interrupt flag |
| rxbuf_o | output | 8 | Receive buffer contents |
| buf_full_o | output | 1 | Buffer holds an unread byte |
| ovf_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Level interrupt request |

## Verification
The host read strobe and the completion of a byte can land on the same system clock edge. In that case the decision to acknowledge and store depends on which of the two is applied first. The bench derives the exact commit cycle from the synchronizer depth after the eighth SCL rise and pulses the read strobe there. It expects the new byte to be acknowledged and stored, with the buffer still marked full. In the same way it pulses the overflow and interrupt clears on a commit that overflows, and it expects both flags to remain set.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned BYTE_W = ADDR_W + 1;
  localparam int unsigned CNT_W  = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_ACK_WAIT,
    ST_ACK
  } rx_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[STAGES-1:0], line_i};
  end

  assign level_o = sh_q[STAGES-1];
  assign rise_o  = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o  = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/i2c_rx_engine.sv
module i2c_rx_engine
  import i2c_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_lvl_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_lvl_i,
  input  logic              sda_rise_i,
  input  logic              sda_fall_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              accept_i,
  output logic              byte_done_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              sda_oe_o
);
  rx_state_e         state_q;
  logic [BYTE_W-1:0] shreg_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              ack_q;
  logic              oe_q;

  logic start_det, stop_det, in_byte, last_bit, addr_hit;

  assign start_det = sda_fall_i & scl_lvl_i;
  assign stop_det  = sda_rise_i & scl_lvl_i;
  assign rx_byte_o = {shreg_q[BYTE_W-2:0], sda_lvl_i};
  assign in_byte   = (state_q == ST_ADDR) || (state_q == ST_DATA);
  assign last_bit  = scl_rise_i && in_byte && (cnt_q == CNT_W'(BYTE_W - 1));
  assign addr_hit  = (rx_byte_o[BYTE_W-1:1] == own_addr_i) && !rx_byte_o[0];
  // completed byte that the host side must account for
  assign byte_done_o = last_bit && !start_det && !stop_det &&
                       ((state_q == ST_DATA) || addr_hit);
  assign sda_oe_o = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      shreg_q <= '0;
      cnt_q   <= '0;
      ack_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else if (start_det) begin
      state_q <= ST_ADDR;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
    end else if (stop_det) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_DATA: begin
          if (scl_rise_i) begin
            shreg_q <= rx_byte_o;
            cnt_q   <= cnt_q + 1'b1;
            if (last_bit) begin
              if (state_q == ST_ADDR && !addr_hit) begin
                state_q <= ST_IDLE;
              end else begin
                state_q <= ST_ACK_WAIT;
                ack_q   <= accept_i;
              end
            end
          end
        end
        ST_ACK_WAIT: begin
          if (scl_fall_i) begin
            oe_q    <= ack_q;
            state_q <= ST_ACK;
          end
        end
        ST_ACK: begin
          if (scl_fall_i) begin
            oe_q    <= 1'b0;
            cnt_q   <= '0;
            state_q <= ST_DATA;
          end
        end
        default: ;
      endcase
    end
  end

  // R3
  oe_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> $past(state_q) == ST_ACK_WAIT);
  // R1
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_oe_o);
endmodule

// File: rtl/i2c_rx_slave.sv
module i2c_rx_slave
  import i2c_rx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              rd_strobe_i,
  input  logic              ovf_clr_i,
  input  logic              irq_clr_i,
  output logic [BYTE_W-1:0] rxbuf_o,
  output logic              buf_full_o,
  output logic              ovf_o,
  output logic              irq_o
);
  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;
  logic byte_done, accept;
  logic [BYTE_W-1:0] rx_byte;

  logic [BYTE_W-1:0] rx_buf_q;
  logic              buf_full_q, ovf_q, irq_q;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk_i, .rst_ni, .line_i(scl_i),
    .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
  );

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk_i, .rst_ni, .line_i(sda_i),
    .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
  );

  i2c_rx_engine u_engine (
    .clk_i, .rst_ni,
    .scl_lvl_i(scl_lvl), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .sda_lvl_i(sda_lvl), .sda_rise_i(sda_rise), .sda_fall_i(sda_fall),
    .own_addr_i,
    .accept_i(accept),
    .byte_done_o(byte_done),
    .rx_byte_o(rx_byte),
    .sda_oe_o
  );

  // a read in the commit cycle frees the slot first
  assign accept = (!buf_full_q || rd_strobe_i) && !ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_buf_q   <= '0;
      buf_full_q <= 1'b0;
      ovf_q      <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      if (byte_done && accept) begin
        rx_buf_q   <= rx_byte;
        buf_full_q <= 1'b1;
      end else if (rd_strobe_i) begin
        buf_full_q <= 1'b0;
      end

      if (byte_done && !accept) ovf_q <= 1'b1;
      else if (ovf_clr_i)       ovf_q <= 1'b0;

      if (byte_done)      irq_q <= 1'b1;
      else if (irq_clr_i) irq_q <= 1'b0;
    end
  end

  assign rxbuf_o    = rx_buf_q;
  assign buf_full_o = buf_full_q;
  assign ovf_o      = ovf_q;
  assign irq_o      = irq_q;

  // R6
  buf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done && buf_full_q && !rd_strobe_i) |=> $stable(rx_buf_q) && ovf_q);
  // R7
  ovf_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done && ovf_q) |=> $stable(rx_buf_q) && ovf_q);
  // R8
  full_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(buf_full_q) |-> $past(rd_strobe_i));
  // R9
  ovf_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ovf_q) |-> $past(ovf_clr_i) && !$past(byte_done));
  // R10
  irq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_q) |-> $past(irq_clr_i) && !$past(byte_done));
  // R11
  read_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done && rd_strobe_i && !ovf_q) |=> buf_full_q);
endmodule

// File: tb/i2c_rx_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_rx_slave_tb_top;
  localparam logic [6:0] OWN = 7'h5A;
  localparam int NV = 6;
  // {addr[16:10], dir[9], data[8:1], expect_match[0]}
  localparam logic [16:0] VEC [NV] = '{
    {7'h5A, 1'b0, 8'hC3, 1'b1},
    {7'h5A, 1'b1, 8'h11, 1'b0},
    {7'h2D, 1'b0, 8'hFF, 1'b0},
    {7'h5A, 1'b0, 8'h00, 1'b1},
    {7'h5B, 1'b0, 8'hA5, 1'b0},
    {7'h5A, 1'b0, 8'h81, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, m_sda = 1'b1;
  logic rd = 1'b0, oclr = 1'b0, iclr = 1'b0;
  logic sda_oe, buf_full, ovf, irq;
  logic [7:0] rxbuf;
  logic sda_line;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  i2c_rx_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .own_addr_i(OWN), .rd_strobe_i(rd),
    .ovf_clr_i(oclr), .irq_clr_i(iclr), .rxbuf_o(rxbuf),
    .buf_full_o(buf_full), .ovf_o(ovf), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; scl = 1'b1; wt(8);
    m_sda = 1'b0; wt(8);
    scl = 1'b0; wt(8);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wt(4);
    scl = 1'b1; wt(8);
    m_sda = 1'b1; wt(8);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; wt(4);
    scl = 1'b1; wt(8);
    scl = 1'b0; wt(4);
  endtask

  // pulse: [0] read, [1] overflow clear, [2] irq clear, all in the commit cycle
  task automatic send_byte(input logic [7:0] b, input logic [2:0] pulse,
                           output logic ack, output logic rel);
    for (int i = 7; i > 0; i--) send_bit(b[i]);
    m_sda = b[0]; wt(4);
    scl = 1'b1; wt(2);
    rd = pulse[0]; oclr = pulse[1]; iclr = pulse[2];
    wt(1);
    rd = 1'b0; oclr = 1'b0; iclr = 1'b0;
    wt(5);
    scl = 1'b0; wt(4);
    m_sda = 1'b1;
    ack = sda_oe;
    scl = 1'b1; wt(8);
    scl = 1'b0; wt(4);
    rel = ~sda_oe;
  endtask

  task automatic pulse_rd();   rd = 1'b1;   wt(1); rd = 1'b0;   wt(1); endtask
  task automatic pulse_oclr(); oclr = 1'b1; wt(1); oclr = 1'b0; wt(1); endtask
  task automatic pulse_iclr(); iclr = 1'b1; wt(1); iclr = 1'b0; wt(1); endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1 actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic ack, rel;
    logic [7:0] ab;
    wt(3); rst_n = 1'b1; wt(3);

    // reset state
    chk(!sda_oe && !buf_full && !ovf && !irq && rxbuf == 8'h00, "R1 reset",
        {sda_oe, buf_full, ovf, irq, rxbuf}, 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      ab = {VEC[v][16:10], VEC[v][9]};
      bus_start();
      send_byte(ab, 3'b000, ack, rel);
      if (VEC[v][0]) begin
        chk(ack == 1'b1 && rel, "R3 addr ack", {ack, rel}, 2'b11);
        chk(rxbuf == ab && buf_full && irq, "R2 R3 addr stored", {buf_full, irq, rxbuf}, {2'b11, ab});
        pulse_rd();
        chk(!buf_full, "R8 read clears full", buf_full, 0);
        send_byte(VEC[v][8:1], 3'b000, ack, rel);
        chk(ack == 1'b1 && rel, "R4 data ack", {ack, rel}, 2'b11);
        chk(rxbuf == VEC[v][8:1] && buf_full, "R4 data stored", {buf_full, rxbuf}, {1'b1, VEC[v][8:1]});
        pulse_rd();
      end else begin
        chk(ack == 1'b0 && !buf_full && !irq && !ovf, "R5 mismatch ignored",
            {ack, buf_full, irq, ovf}, 0);
        send_byte(VEC[v][8:1], 3'b000, ack, rel);
        chk(ack == 1'b0 && !buf_full && !irq, "R5 bus ignored after mismatch",
            {ack, buf_full, irq}, 0);
      end
      bus_stop();
      pulse_iclr();
      chk(!irq, "R10 irq clear", irq, 0);
    end

    // overflow sequence
    bus_start();
    send_byte({OWN, 1'b0}, 3'b000, ack, rel);
    chk(ack && rxbuf == 8'hB4 && buf_full, "R3 addr before overflow", {ack, buf_full, rxbuf}, {2'b11, 8'hB4});
    pulse_iclr();
    send_byte(8'h37, 3'b000, ack, rel);
    chk(!ack && rxbuf == 8'hB4 && ovf && buf_full, "R6 full refuses",
        {ack, ovf, buf_full, rxbuf}, {3'b011, 8'hB4});
    chk(irq, "R10 irq on refused byte", irq, 1);
    pulse_rd();
    chk(!buf_full && ovf, "R8 read keeps overflow", {buf_full, ovf}, 2'b01);
    send_byte(8'h99, 3'b000, ack, rel);
    chk(!ack && rxbuf == 8'hB4 && !buf_full && ovf, "R7 overflow refuses",
        {ack, buf_full, ovf, rxbuf}, {3'b001, 8'hB4});
    pulse_oclr();
    chk(!ovf, "R9 explicit clear", ovf, 0);
    pulse_iclr();
    chk(!irq, "R10 irq clear after overflow", irq, 0);
    send_byte(8'h6E, 3'b000, ack, rel);
    chk(ack && rxbuf == 8'h6E && buf_full, "R4 accepted after clear", {ack, buf_full, rxbuf}, {2'b11, 8'h6E});
    // read coincident with commit
    send_byte(8'h42, 3'b001, ack, rel);
    chk(ack && rxbuf == 8'h42 && buf_full && !ovf, "R11 read at commit",
        {ack, buf_full, ovf, rxbuf}, {3'b110, 8'h42});
    // clears coincident with an overflowing commit
    send_byte(8'h24, 3'b110, ack, rel);
    chk(!ack && ovf && irq && rxbuf == 8'h42, "R9 R10 set wins over clear",
        {ack, ovf, irq, rxbuf}, {3'b011, 8'h42});
    bus_stop();
    pulse_oclr(); pulse_rd(); pulse_iclr();

    // traffic without a start is ignored
    send_byte({OWN, 1'b0}, 3'b000, ack, rel);
    chk(!ack && !buf_full && !irq, "R1 no start no effect", {ack, buf_full, irq}, 0);

    // repeated start in the middle of a data byte
    bus_start();
    send_byte({OWN, 1'b0}, 3'b000, ack, rel);
    pulse_rd(); pulse_iclr();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_start();
    send_byte({OWN, 1'b0}, 3'b000, ack, rel);
    chk(ack && rel && buf_full && rxbuf == 8'hB4, "R1 repeated start", {ack, rel, buf_full, rxbuf}, {3'b111, 8'hB4});
    bus_stop();
    chk(!sda_oe, "R1 released after stop", sda_oe, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule